// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit carries out the rotate-right group of integer instructions in a 64-bit pipeline. Each cycle with `in_valid` high it decodes three instruction fields (the register-select field, the 5-bit shift-amount field and the 6-bit function code) and rotates the 64-bit source operand. The rotate amount comes from one of three places: the immediate field, the immediate field plus 32, or the low bits of a second register operand. The 32-bit forms rotate only the low word and then sign-extend it to 64 bits.

The result and a valid flag are registered and appear one clock after the request. Shift encodings that share the opcode space, and any other pattern outside the five rotate forms, are not executed here. They raise `unhandled` in the same cycle where the result would otherwise have appeared, so the issuing stage can send them elsewhere or trap.

Top module: `rotr_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res`, `res_vld` and `unhandled` are all zero.
- R2: With `rs_fld` = 5'b00001 and `fn_fld` = 6'b000010, the low 32 bits of `src_op` are rotated right by `sh_fld` (0..31). Bits 63..32 of `src_op` have no effect.
- R3: With `rs_fld` = 5'b00001 and `fn_fld` = 6'b111010, all 64 bits of `src_op` are rotated right by `sh_fld` (0..31).
- R4: With `rs_fld` = 5'b00001 and `fn_fld` = 6'b111110, all 64 bits of `src_op` are rotated right by `sh_fld` + 32 (32..63).
- R5: With `sh_fld` = 5'b00001 and `fn_fld` = 6'b000110, the low 32 bits of `src_op` are rotated right by `amt_op[4:0]`. Bits 63..5 of `amt_op` are ignored.
- R6: With `sh_fld` = 5'b00001 and `fn_fld` = 6'b010110, all 64 bits of `src_op` are rotated right by `amt_op[5:0]`. Bits 63..6 of `amt_op` are ignored.
- R7: For both 32-bit forms (R2, R5), `res[63:32]` equals 32 copies of `res[31]`.
- R8: A rotate amount of zero returns the operand unchanged. For the 32-bit forms this means the low word, sign-extended.
- R9: An accepted request that matches none of the five forms sets `unhandled` in the next cycle. In that cycle `res_vld` stays low and `res` keeps its previous value.
- R10: A matching accepted request sets `res_vld` exactly one cycle later. A cycle with `in_valid` low raises neither flag in the next cycle and leaves `res` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| rs_fld | input | 5 | Register-select field; 00001 selects the immediate forms |
| sh_fld | input | 5 | Shift-amount field; immediate amount, or marker 00001 for variable forms |
| fn_fld | input | 6 | Function code |
| src_op | input | 64 | Operand to rotate |
| amt_op | input | 64 | Register holding the variable rotate amount |
| res | output | 64 | Registered result |
| res_vld | output | 1 | `res` holds a new rotate result |
| unhandled | output | 1 | Previous request was not a rotate form |

## Verification
The source operands use distinct byte patterns, so an off-by-one amount or a rotate of the wrong width shows up as a different value. Each 32-bit form gets a source whose upper word is set. This separates a true 32-bit rotate with sign extension from a 64-bit rotate, and bit-31 values of both polarities are used. The `amt_op` patterns carry ones above the used bits, which exposes any extra amount bit that leaks in. The +32 form is tried at both ends of its range. Near-miss encodings (a shift function under the rotate marker, and a rotate function with the marker off by one bit) are then mixed with randomly drawn valid requests, and the bench model is compared with the design on every clock.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_W32_IMM,
    RK_W64_IMM,
    RK_W64_HI,
    RK_W32_REG,
    RK_W64_REG
  } rot_kind_e;

  localparam logic [4:0] MARK_ROT  = 5'b00001;
  localparam logic [5:0] FN_W32IMM = 6'b000010;
  localparam logic [5:0] FN_W64IMM = 6'b111010;
  localparam logic [5:0] FN_W64HI  = 6'b111110;
  localparam logic [5:0] FN_W32REG = 6'b000110;
  localparam logic [5:0] FN_W64REG = 6'b010110;
endpackage

// File: rtl/rotr_decode.sv
module rotr_decode
  import rotr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [4:0]    rs_fld,
  input  logic [4:0]    sh_fld,
  input  logic [5:0]    fn_fld,
  input  logic [AW-1:0] amt_low,
  output rot_kind_e     kind,
  output logic [AW-1:0] amt,
  output logic          wide
);
  localparam int HAW = AW - 1;
  localparam int HW  = 2 ** HAW;

  always_comb begin
    kind = RK_NONE;
    if (rs_fld == MARK_ROT) begin
      unique case (fn_fld)
        FN_W32IMM: kind = RK_W32_IMM;
        FN_W64IMM: kind = RK_W64_IMM;
        FN_W64HI:  kind = RK_W64_HI;
        default:   kind = RK_NONE;
      endcase
    end
    if (sh_fld == MARK_ROT && kind == RK_NONE) begin
      unique case (fn_fld)
        FN_W32REG: kind = RK_W32_REG;
        FN_W64REG: kind = RK_W64_REG;
        default:   kind = RK_NONE;
      endcase
    end
  end

  always_comb begin
    amt  = '0;
    wide = 1'b1;
    unique case (kind)
      RK_W32_IMM: begin amt = AW'(sh_fld); wide = 1'b0; end
      RK_W64_IMM: amt = AW'(sh_fld);
      RK_W64_HI:  amt = AW'(sh_fld) + AW'(HW);
      RK_W32_REG: begin amt = AW'(amt_low[HAW-1:0]); wide = 1'b0; end
      RK_W64_REG: amt = amt_low;
      default:    amt = '0;
    endcase
  end
endmodule

// File: rtl/rotr_core.sv
module rotr_core #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 2 ** k;
    assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/rotr_unit.sv
module rotr_unit
  import rotr_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    rs_fld,
  input  logic [4:0]    sh_fld,
  input  logic [5:0]    fn_fld,
  input  logic [DW-1:0] src_op,
  input  logic [DW-1:0] amt_op,
  output logic [DW-1:0] res,
  output logic          res_vld,
  output logic          unhandled
);
  localparam int HW  = DW / 2;
  localparam int AW  = $clog2(DW);
  localparam int HAW = $clog2(HW);

  rot_kind_e     kind;
  logic [AW-1:0] amt;
  logic          wide;
  logic [DW-1:0] rot_full;
  logic [HW-1:0] rot_half;
  logic [DW-1:0] nxt;
  logic          hit;

  rotr_decode #(.AW(AW)) u_dec (
    .rs_fld (rs_fld),
    .sh_fld (sh_fld),
    .fn_fld (fn_fld),
    .amt_low(amt_op[AW-1:0]),
    .kind   (kind),
    .amt    (amt),
    .wide   (wide)
  );

  rotr_core #(.W(DW), .AW(AW)) u_rot_full (
    .din (src_op),
    .amt (amt),
    .dout(rot_full)
  );

  rotr_core #(.W(HW), .AW(HAW)) u_rot_half (
    .din (src_op[HW-1:0]),
    .amt (amt[HAW-1:0]),
    .dout(rot_half)
  );

  assign hit = (kind != RK_NONE);
  assign nxt = wide ? rot_full : {{HW{rot_half[HW-1]}}, rot_half};

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_vld   <= 1'b0;
      unhandled <= 1'b0;
    end else begin
      res_vld   <= in_valid && hit;
      unhandled <= in_valid && !hit;
      if (in_valid && hit) res <= nxt;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(res_vld && unhandled)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_vld && !unhandled && res == $past(res))); // R10

  AST_SEXT_W32: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rs_fld == MARK_ROT && fn_fld == FN_W32IMM)
      |=> (res[DW-1:HW] == {HW{res[HW-1]}})); // R7

  AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rs_fld == MARK_ROT && fn_fld == FN_W64IMM && sh_fld == 5'd0)
      |=> (res == $past(src_op))); // R8

  AST_HI_SWAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rs_fld == MARK_ROT && fn_fld == FN_W64HI && sh_fld == 5'd0)
      |=> (res == {$past(src_op[HW-1:0]), $past(src_op[DW-1:HW])})); // R4

  AST_UNH_HOLD: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!res_vld && $stable(res))); // R9
endmodule

// File: tb/rotr_unit_bench.sv
`timescale 1ns/1ps
module rotr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  rs_fld = '0;
  logic [4:0]  sh_fld = '0;
  logic [5:0]  fn_fld = '0;
  logic [63:0] src_op = '0;
  logic [63:0] amt_op = '0;
  logic [63:0] res;
  logic        res_vld;
  logic        unhandled;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [63:0] m_res = '0;

  always #4 clk = ~clk;

  rotr_unit u_rotr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .rs_fld(rs_fld), .sh_fld(sh_fld), .fn_fld(fn_fld),
    .src_op(src_op), .amt_op(amt_op),
    .res(res), .res_vld(res_vld), .unhandled(unhandled)
  );

  // one-bit-at-a-time rotate within a width of w bits
  function automatic logic [63:0] slow_rot(input logic [63:0] x, input int w, input int n);
    logic [63:0] v = x;
    for (int i = 0; i < n; i++) begin
      logic b = v[0];
      v = v >> 1;
      v[w-1] = b;
    end
    if (w == 32) begin
      for (int j = 32; j < 64; j++) v[j] = v[31];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, then compare with the model one cycle later
  task automatic step(input string tag, input bit v, input logic [4:0] rs, input logic [4:0] sh,
                      input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b);
    bit ev = 1'b0;
    bit eu = 1'b0;
    int w = 0;
    int n = 0;
    in_valid = v; rs_fld = rs; sh_fld = sh; fn_fld = fn; src_op = a; amt_op = b;
    if (rs == 5'd1 && fn == 6'b000010)      begin w = 32; n = sh; end
    else if (rs == 5'd1 && fn == 6'b111010) begin w = 64; n = sh; end
    else if (rs == 5'd1 && fn == 6'b111110) begin w = 64; n = sh + 32; end
    else if (sh == 5'd1 && fn == 6'b000110) begin w = 32; n = b % 32; end
    else if (sh == 5'd1 && fn == 6'b010110) begin w = 64; n = b % 64; end
    if (v && w != 0) begin ev = 1'b1; m_res = slow_rot(a, w, n); end
    else if (v) eu = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 64'(res_vld), 64'(ev));
    check({tag, " unhandled"}, 64'(unhandled), 64'(eu));
    check({tag, " result"}, res, m_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", res, 64'd0);
    check("R1 reset valid", 64'(res_vld), 64'd0);
    rst = 1'b0;
    step("R1 first cycle", 0, 5'd0, 5'd0, 6'd0, 64'd0, 64'd0);

    step("R2 imm32 by 4",   1, 5'd1, 5'd4,  6'b000010, 64'hFFFF0000_12345678, 64'd0);
    step("R2 imm32 by 31",  1, 5'd1, 5'd31, 6'b000010, 64'hAAAA5555_80000001, 64'd0);
    step("R7 imm32 positive", 1, 5'd1, 5'd1, 6'b000010, 64'hFFFFFFFF_00000002, 64'd0);
    step("R3 imm64 by 8",   1, 5'd1, 5'd8,  6'b111010, 64'h01234567_89ABCDEF, 64'd0);
    step("R3 imm64 by 31",  1, 5'd1, 5'd31, 6'b111010, 64'hF00D0000_0000BEEF, 64'd0);
    step("R4 hi by 32",     1, 5'd1, 5'd0,  6'b111110, 64'h01234567_89ABCDEF, 64'd0);
    step("R4 hi by 63",     1, 5'd1, 5'd31, 6'b111110, 64'h80000000_00000001, 64'd0);
    step("R5 var32 by 3",   1, 5'd9, 5'd1,  6'b000110, 64'h12345678_0000000F, 64'hFFFFFFFF_FFFFFFE3);
    step("R6 var64 by 5",   1, 5'd7, 5'd1,  6'b010110, 64'hDEADBEEF_CAFEF00D, 64'hFFFF0000_000000C5);
    step("R8 imm64 by 0",   1, 5'd1, 5'd0,  6'b111010, 64'h0F1E2D3C_4B5A6978, 64'd0);
    step("R8 var32 by 0",   1, 5'd3, 5'd1,  6'b000110, 64'h00000000_9ABCDEF0, 64'hFFFFFFFF_FFFFFFE0);
    step("R9 shift under marker", 1, 5'd1, 5'd4, 6'b000000, 64'h1111, 64'd0);
    step("R9 wrong var fn",   1, 5'd5, 5'd1, 6'b000100, 64'h2222, 64'd3);
    step("R9 rs off by one",  1, 5'd2, 5'd4, 6'b000010, 64'h3333, 64'd0);
    step("R9 marker off",     1, 5'd5, 5'd2, 6'b000110, 64'h4444, 64'd1);
    step("R10 idle valid enc", 0, 5'd1, 5'd4, 6'b111010, 64'h5555, 64'd0);
    step("R10 after idle",     1, 5'd1, 5'd12, 6'b111010, 64'h76543210_FEDCBA98, 64'd0);

    for (int i = 0; i < 60; i++) begin
      logic [5:0] fns [5] = '{6'b000010, 6'b111010, 6'b111110, 6'b000110, 6'b010110};
      int k = $urandom_range(4);
      logic [4:0] sh = 5'($urandom);
      logic [4:0] rs = 5'd1;
      if (k >= 3) begin rs = 5'($urandom); sh = 5'd1; end
      step("R10 random", ($urandom_range(3) != 0), rs, sh, fns[k],
           {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule